// File: doc/BRIEF.md
# Four-Phase Instruction Cycle Sequencer

This block sequences instructions for a small accumulator-style controller core. Every instruction cycle is split into four phases that advance one per clock: decode, operand read, process, write-back. The block owns the program counter, an instruction register, an 8-bit working register `W`, an 8-bit output port, a return-address stack and an upper-address latch. The program store is external: the block presents the fetch address on `pc_o` and takes the 14-bit instruction word back on `instr_i` in the same cycle.

The pipeline is one deep. During the write phase of each instruction cycle, the word at `pc_o` is loaded into the instruction register while the current instruction commits its results. Two named states drive this. `CY_RUN` means the word in the instruction register executes in the current cycle. `CY_BUBBLE` means that word is disabled. The transition `RUN->BUBBLE` follows every flow-control instruction and every skip that is taken. The transition `BUBBLE->RUN` always follows one bubble cycle. `RUN->RUN` covers every other case. Reset enters `CY_BUBBLE`.

The phase machine has four named states: `PH_DEC`, `PH_RD`, `PH_PROC` and `PH_WR`. It follows the fixed ring `DEC->RD->PROC->WR->DEC`. Because there is no cache and no wait state, the timing of a program depends only on its instruction sequence. A computed jump can therefore set the width of an output pulse from data.

Top module: `qcycle_seq`

## Requirements
- R1: `phase_o` is one-hot and equals 4'b0001 during reset and in the first clock after it. Each clock it moves one place up, ring order 0001->0010->0100->1000->0001, and one instruction cycle is four clocks.
- R2: An instruction word is {op[13:10], field[9:0]}. Single-cycle ops are: NOP = 0 and 15; LDW = 1 (W = field[7:0]); BSET = 2 and BCLR = 3 (set or clear port bit field[2:0]); SETHI = 13 (latch = field[4:0]). Each takes one instruction cycle. W, the port and the latch change only at the end of the write phase.
- R3: GOTO = 4, CALL = 5, RET = 6, RETL = 7 (also W = field[7:0]) and RETI = 14 always take two instruction cycles. In the second cycle `exec_en_o` is low and `pc_o` shows the target.
- R4: DECSZ = 9 and INCSZ = 10 write W-1 or W+1 and skip if the result is zero. BTSC = 11 skips if port bit field[2:0] is 0, and BTSS = 12 skips if it is 1. A skip that is not taken costs one cycle; a taken skip costs two.
- R5: When a skip is taken, the next word is fetched but not executed. It changes neither W, the port, the latch nor the stack, and `pc_o` in the bubble cycle is the skip's address plus 2.
- R6: ADDPC = 8 forms its target from the latch (upper 5 bits) and, as bits 7:0, the low byte of (its own address + 1) plus W, modulo 256. A chain of k BSETs of bit 0 followed by a BCLR, entered this way, holds port bit 0 high for 4*(3-W) clocks when k = 3.
- R7: CALL pushes its own address + 1 onto an 8-entry circular stack. RET, RETL and RETI pop it. A ninth push overwrites the oldest entry, and the entries reset to zero.
- R8: After reset, `pc_o` = 0 and `exec_en_o` = 0 for the first instruction cycle. `pc_o` is the fetch address and changes only at the end of the write phase: in an executing cycle it is the executing address + 1.
- R9: GOTO and CALL targets are {latch[4:2], field[9:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one phase per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 14 | Instruction word at address `pc_o` |
| pc_o | output | 13 | Fetch address |
| phase_o | output | 4 | One-hot phase strobes, bit 0 = decode |
| exec_en_o | output | 1 | High when the current instruction cycle executes |
| port_o | output | 8 | Bit output port |

## Verification
On every clock, the embedded properties check the ring order of the phases, that the PC and the port hold outside the write phase, and that each flow-control instruction and each taken skip is followed by a disabled cycle. They also check that a bubble commits nothing and that jump targets take their upper bits from the latch. Only the bench's program runs can show the full-program behaviour: exact return addresses after the stack wraps, the data-dependent pulse width of a computed jump, and agreement with an instruction-level model cycle by cycle over random programs.

// File: rtl/qcs_pkg.sv
package qcs_pkg;
    localparam int IW    = 14;
    localparam int OP_W  = 4;
    localparam int JW    = 10;
    localparam int NPH   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NOP   = 4'd0,  OP_LDW   = 4'd1,  OP_BSET  = 4'd2,  OP_BCLR  = 4'd3,
        OP_GOTO  = 4'd4,  OP_CALL  = 4'd5,  OP_RET   = 4'd6,  OP_RETL  = 4'd7,
        OP_ADDPC = 4'd8,  OP_DECSZ = 4'd9,  OP_INCSZ = 4'd10, OP_BTSC  = 4'd11,
        OP_BTSS  = 4'd12, OP_SETHI = 4'd13, OP_RETI  = 4'd14, OP_NOP2  = 4'd15
    } op_e;

    typedef enum logic [1:0] {PH_DEC, PH_RD, PH_PROC, PH_WR} phase_e;
    typedef enum logic [1:0] {CL_SINGLE, CL_FLOW, CL_SKIP} class_e;
    typedef enum logic [1:0] {TG_ABS, TG_STACK, TG_COMP} tsel_e;
    typedef enum logic {CY_BUBBLE, CY_RUN} cyc_e;
endpackage

// File: rtl/qcs_phase_gen.sv
module qcs_phase_gen
    import qcs_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    output phase_e         phase_o,
    output logic [NPH-1:0] strobe_o,
    output logic           wr_phase_o
);
    phase_e st_q, st_d;

    always_comb begin
        unique case (st_q)
            PH_DEC:  st_d = PH_RD;
            PH_RD:   st_d = PH_PROC;
            PH_PROC: st_d = PH_WR;
            PH_WR:   st_d = PH_DEC;
            default: st_d = PH_DEC;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PH_DEC;
        else        st_q <= st_d;
    end

    always_comb begin
        phase_o    = st_q;
        strobe_o   = NPH'(1) << st_q;
        wr_phase_o = (st_q == PH_WR);
    end

    // R1
    phase_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PH_WR) |=> (st_q == PH_DEC));

    // R1
    phase_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(strobe_o) == 1);
endmodule

// File: rtl/qcs_ret_stack.sv
module qcs_ret_stack #(
    parameter int DEPTH = 8,
    parameter int DW    = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [DW-1:0] din_i,
    output logic [DW-1:0] top_o
);
    localparam int PW = $clog2(DEPTH);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [PW-1:0] ptr_q;
    logic [DW-1:0] ent [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic [DW-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             q <= '0;
            else if (push_i && ptr_q == PW'(g))     q <= din_i;
        end
        assign ent[g] = q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ptr_q <= '0;
        else if (push_i) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        else if (pop_i)  ptr_q <= (ptr_q == '0) ? LAST : ptr_q - 1'b1;
    end

    always_comb top_o = ent[(ptr_q == '0) ? LAST : ptr_q - 1'b1];

    // R7
    push_pop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_i && pop_i));

    // R7
    pushed_on_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> (top_o == $past(din_i)));
endmodule

// File: rtl/qcs_decode.sv
module qcs_decode
    import qcs_pkg::*;
#(
    parameter int DW  = 8,
    parameter int NB  = 8,
    parameter int HW  = 5
) (
    input  logic [IW-1:0]         ir_i,
    input  logic [DW-1:0]         w_i,
    input  logic [NB-1:0]         bits_i,
    output class_e                cls_o,
    output tsel_e                 tsel_o,
    output logic                  push_o,
    output logic                  pop_o,
    output logic                  w_we_o,
    output logic [DW-1:0]         w_nx_o,
    output logic                  set_o,
    output logic                  clr_o,
    output logic [$clog2(NB)-1:0] bidx_o,
    output logic                  hi_we_o,
    output logic [HW-1:0]         hi_nx_o,
    output logic                  skip_o
);
    localparam int BIW = $clog2(NB);

    op_e           op;
    logic [DW-1:0] lit;
    logic [DW-1:0] w_dec, w_inc;

    always_comb begin
        op      = op_e'(ir_i[IW-1 -: OP_W]);
        lit     = DW'(ir_i[7:0]);
        bidx_o  = ir_i[BIW-1:0];
        hi_nx_o = ir_i[HW-1:0];
        w_dec   = w_i - 1'b1;
        w_inc   = w_i + 1'b1;

        cls_o   = CL_SINGLE;
        tsel_o  = TG_ABS;
        push_o  = 1'b0;
        pop_o   = 1'b0;
        w_we_o  = 1'b0;
        w_nx_o  = w_i;
        set_o   = 1'b0;
        clr_o   = 1'b0;
        hi_we_o = 1'b0;
        skip_o  = 1'b0;

        unique case (op)
            OP_LDW:   begin w_we_o = 1'b1; w_nx_o = lit; end
            OP_BSET:  set_o = 1'b1;
            OP_BCLR:  clr_o = 1'b1;
            OP_SETHI: hi_we_o = 1'b1;
            OP_GOTO:  cls_o = CL_FLOW;
            OP_CALL:  begin cls_o = CL_FLOW; push_o = 1'b1; end
            OP_RET, OP_RETI: begin
                cls_o = CL_FLOW; tsel_o = TG_STACK; pop_o = 1'b1;
            end
            OP_RETL: begin
                cls_o = CL_FLOW; tsel_o = TG_STACK; pop_o = 1'b1;
                w_we_o = 1'b1; w_nx_o = lit;
            end
            OP_ADDPC: begin cls_o = CL_FLOW; tsel_o = TG_COMP; end
            OP_DECSZ: begin
                cls_o = CL_SKIP; w_we_o = 1'b1; w_nx_o = w_dec;
                skip_o = (w_dec == '0);
            end
            OP_INCSZ: begin
                cls_o = CL_SKIP; w_we_o = 1'b1; w_nx_o = w_inc;
                skip_o = (w_inc == '0);
            end
            OP_BTSC: begin cls_o = CL_SKIP; skip_o = !bits_i[bidx_o]; end
            OP_BTSS: begin cls_o = CL_SKIP; skip_o =  bits_i[bidx_o]; end
            default: ;
        endcase
    end
endmodule

// File: rtl/qcycle_seq.sv
module qcycle_seq
    import qcs_pkg::*;
#(
    parameter int PC_W      = 13,
    parameter int LOW_W     = 8,
    parameter int NB        = 8,
    parameter int STK_DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IW-1:0]    instr_i,
    output logic [PC_W-1:0]  pc_o,
    output logic [NPH-1:0]   phase_o,
    output logic             exec_en_o,
    output logic [NB-1:0]    port_o
);
    localparam int DW    = LOW_W;
    localparam int HI_W  = PC_W - LOW_W;
    localparam int JHI_W = PC_W - JW;
    localparam int BIW   = $clog2(NB);

    phase_e          phase;
    logic            wr_ph;
    cyc_e            cyc_q, cyc_d;

    logic [PC_W-1:0] pc_q, tgt, stk_top;
    logic [IW-1:0]   ir_q;
    logic [DW-1:0]   w_q;
    logic [NB-1:0]   port_q;
    logic [HI_W-1:0] hi_q;

    class_e          cls;
    tsel_e           tsel;
    logic            d_push, d_pop, d_wwe, d_set, d_clr, d_hiwe, d_skip;
    logic [DW-1:0]   d_wnx;
    logic [BIW-1:0]  d_bidx;
    logic [HI_W-1:0] d_hinx;
    logic            run, commit, redirect;

    qcs_phase_gen u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_o    (phase),
        .strobe_o   (phase_o),
        .wr_phase_o (wr_ph)
    );

    qcs_decode #(.DW(DW), .NB(NB), .HW(HI_W)) u_dec (
        .ir_i    (ir_q),
        .w_i     (w_q),
        .bits_i  (port_q),
        .cls_o   (cls),
        .tsel_o  (tsel),
        .push_o  (d_push),
        .pop_o   (d_pop),
        .w_we_o  (d_wwe),
        .w_nx_o  (d_wnx),
        .set_o   (d_set),
        .clr_o   (d_clr),
        .bidx_o  (d_bidx),
        .hi_we_o (d_hiwe),
        .hi_nx_o (d_hinx),
        .skip_o  (d_skip)
    );

    qcs_ret_stack #(.DEPTH(STK_DEPTH), .DW(PC_W)) u_stk (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (commit && d_push),
        .pop_i  (commit && d_pop),
        .din_i  (pc_q),
        .top_o  (stk_top)
    );

    always_comb begin
        run      = (cyc_q == CY_RUN);
        commit   = run && wr_ph;
        redirect = (cls == CL_FLOW);
    end

    always_comb begin
        unique case (tsel)
            TG_ABS:   tgt = {hi_q[HI_W-1 -: JHI_W], ir_q[JW-1:0]};
            TG_STACK: tgt = stk_top;
            TG_COMP:  tgt = {hi_q, pc_q[LOW_W-1:0] + w_q};
            default:  tgt = pc_q;
        endcase
    end

    // cycle state machine: next state
    always_comb begin
        cyc_d = cyc_q;
        if (wr_ph) begin
            unique case (cyc_q)
                CY_BUBBLE: cyc_d = CY_RUN;
                CY_RUN:    cyc_d = (redirect || d_skip) ? CY_BUBBLE : CY_RUN;
                default:   cyc_d = CY_RUN;
            endcase
        end
    end

    // cycle state machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc_q <= CY_BUBBLE;
        else        cyc_q <= cyc_d;
    end

    // fetch and commit, write phase only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q   <= '0;
            ir_q   <= '0;
            w_q    <= '0;
            port_q <= '0;
            hi_q   <= '0;
        end else if (wr_ph) begin
            ir_q <= instr_i;
            unique case (cyc_q)
                CY_BUBBLE: pc_q <= pc_q + 1'b1;
                CY_RUN: begin
                    if (d_wwe)  w_q <= d_wnx;
                    if (d_set)  port_q[d_bidx] <= 1'b1;
                    if (d_clr)  port_q[d_bidx] <= 1'b0;
                    if (d_hiwe) hi_q <= d_hinx;
                    pc_q <= redirect ? tgt : pc_q + 1'b1;
                end
                default: pc_q <= pc_q;
            endcase
        end
    end

    // outputs
    always_comb begin
        pc_o      = pc_q;
        exec_en_o = run;
        port_o    = port_q;
    end

    // R3
    flow_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && cls == CL_FLOW) |=> !exec_en_o);

    // R4
    skip_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && d_skip) |=> !exec_en_o);

    // R8
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ph |=> $stable(pc_o));

    // R2
    port_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ph |=> $stable(port_o));

    // R5
    bubble_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ph && !exec_en_o) |=> ($stable(port_o) && $stable(w_q) && $stable(hi_q)));

    // R9
    goto_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && tsel == TG_ABS && cls == CL_FLOW)
            |=> (pc_o[PC_W-1 -: JHI_W] == $past(hi_q[HI_W-1 -: JHI_W])));

    // R1
    cycle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(exec_en_o) |-> (phase == PH_DEC));
endmodule

// File: tb/qcycle_seq_tb.sv
`timescale 1ns/1ps
module qcycle_seq_tb;
    localparam int ROMN = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] instr;
    logic [12:0] pc_o;
    logic [3:0]  phase_o;
    logic        exec_en_o;
    logic [7:0]  port_o;

    logic [13:0] rom [ROMN];

    int nchk = 0;
    int nfail = 0;

    // model state
    logic [12:0] m_next;
    logic [7:0]  m_w, m_out;
    logic [4:0]  m_hi;
    logic [12:0] m_stk [8];
    logic [2:0]  m_sp;
    bit          m_bub;
    string       m_tag;
    string       m_bub_tag;
    int          ph;
    logic [12:0] q2_pc;

    always #10 clk = ~clk;

    assign instr = rom[pc_o[5:0]];

    qcycle_seq u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .instr_i   (instr),
        .pc_o      (pc_o),
        .phase_o   (phase_o),
        .exec_en_o (exec_en_o),
        .port_o    (port_o)
    );

    function automatic logic [13:0] enc(int op, int fld);
        return {4'(op), 10'(fld)};
    endfunction

    function automatic logic [13:0] rand_ins();
        int op = int'($urandom_range(15, 0));
        int f;
        case (op)
            4, 5:           f = int'($urandom_range(ROMN - 1, 0));
            2, 3, 11, 12:   f = int'($urandom_range(7, 0));
            13:             f = int'($urandom_range(31, 0));
            default:        f = int'($urandom_range(255, 0));
        endcase
        return enc(op, f);
    endfunction

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_next = '0; m_w = '0; m_out = '0; m_hi = '0; m_sp = '0;
        for (int i = 0; i < 8; i++) m_stk[i] = '0;
        m_bub = 1'b1; m_tag = "R8"; m_bub_tag = "R8";
    endtask

    task automatic model_exec();
        logic [12:0] a = m_next;
        logic [13:0] ins = rom[a[5:0]];
        logic [12:0] nx = a + 13'd1;
        logic [7:0]  lo;
        logic [2:0]  b = ins[2:0];
        bit          bub = 1'b0;
        m_tag = "R2";
        case (int'(ins[13:10]))
            1:  m_w = ins[7:0];
            2:  m_out[b] = 1'b1;
            3:  m_out[b] = 1'b0;
            13: m_hi = ins[4:0];
            4:  begin nx = {m_hi[4:2], ins[9:0]}; bub = 1; m_tag = "R3,R9"; end
            5:  begin
                    m_stk[m_sp] = a + 13'd1; m_sp = m_sp + 3'd1;
                    nx = {m_hi[4:2], ins[9:0]}; bub = 1; m_tag = "R7,R9";
                end
            6, 14: begin m_sp = m_sp - 3'd1; nx = m_stk[m_sp]; bub = 1; m_tag = "R7"; end
            7:  begin
                    m_sp = m_sp - 3'd1; nx = m_stk[m_sp]; m_w = ins[7:0];
                    bub = 1; m_tag = "R3,R7";
                end
            8:  begin
                    lo = a[7:0] + 8'd1 + m_w;
                    nx = {m_hi, lo}; bub = 1; m_tag = "R6";
                end
            9:  begin m_w = m_w - 8'd1; bub = (m_w == 0); m_tag = "R4"; end
            10: begin m_w = m_w + 8'd1; bub = (m_w == 0); m_tag = "R4"; end
            11: begin bub = !m_out[b]; m_tag = "R4"; end
            12: begin bub =  m_out[b]; m_tag = "R4"; end
            default: ;
        endcase
        if (bub && int'(ins[13:10]) inside {9, 10, 11, 12}) begin
            nx = a + 13'd2;
            m_bub_tag = "R4,R5";
        end else if (bub) begin
            m_bub_tag = "R3";
        end
        m_next = nx;
        m_bub  = bub;
    endtask

    // reset, then run ncyc instruction cycles against the model
    task automatic run(int ncyc, output int hi_clks);
        int cyc = 0;
        hi_clks = 0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(phase_o == 4'b0001, "R1", "reset phase", phase_o, 1);
        chk(pc_o == 0 && exec_en_o == 0 && port_o == 0, "R8", "reset state",
            {pc_o, exec_en_o, port_o}, 0);
        rst_n = 1'b1;
        model_reset();
        ph = 0;
        while (cyc < ncyc) begin
            @(posedge clk);
            ph = (ph + 1) % 4;
            @(negedge clk);
            chk(phase_o == 4'(1 << ph), "R1", "phase", phase_o, 1 << ph);
            if (port_o[0]) hi_clks++;
            if (ph == 1) begin
                cyc++;
                q2_pc = pc_o;
                chk(port_o == m_out, m_tag, "port", port_o, m_out);
                if (m_bub) begin
                    chk(exec_en_o == 1'b0, m_bub_tag, "bubble exec_en", exec_en_o, 0);
                    chk(pc_o == m_next, m_bub_tag, "bubble pc", pc_o, m_next);
                    m_tag = (m_bub_tag == "R4,R5") ? "R5" : m_tag;
                    m_bub = 1'b0;
                end else begin
                    chk(exec_en_o == 1'b1, m_tag, "exec_en", exec_en_o, 1);
                    chk(pc_o == m_next + 13'd1, "R8", "exec pc", pc_o, m_next + 13'd1);
                    model_exec();
                end
            end else if (ph == 3) begin
                chk(pc_o == q2_pc, "R8", "pc hold", pc_o, q2_pc);
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        int hc;
        void'($urandom(32'd2024));
        for (int i = 0; i < ROMN; i++) rom[i] = enc(0, 0);

        // directed: skips taken and not taken, skipped words inert
        rom[0]  = enc(1, 1);   rom[1]  = enc(9, 0);   rom[2]  = enc(2, 1);
        rom[3]  = enc(2, 2);   rom[4]  = enc(1, 5);   rom[5]  = enc(9, 0);
        rom[6]  = enc(2, 3);   rom[7]  = enc(12, 3);  rom[8]  = enc(2, 4);
        rom[9]  = enc(11, 3);  rom[10] = enc(2, 5);   rom[11] = enc(4, 11);
        run(30, hc);
        chk(port_o == 8'h2C, "R5", "skip program port", port_o, 8'h2C);

        // directed: computed jump pulse width, W = 0..2
        for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < ROMN; i++) rom[i] = enc(0, 0);
            rom[0] = enc(3, 0); rom[1] = enc(1, k); rom[2] = enc(8, 0);
            rom[3] = enc(2, 0); rom[4] = enc(2, 0); rom[5] = enc(2, 0);
            rom[6] = enc(3, 0); rom[7] = enc(4, 7);
            run(20, hc);
            chk(hc == 4 * (3 - k), "R6", "pulse clocks", hc, 4 * (3 - k));
        end

        // directed: nine nested calls wrap the stack, then chained returns
        for (int i = 0; i < ROMN; i++) rom[i] = enc(0, 0);
        rom[0] = enc(5, 10);
        for (int i = 10; i < 18; i++) rom[i] = enc(5, i + 1);
        rom[18] = enc(6, 0);
        run(60, hc);

        // directed: latch drives goto upper bits
        for (int i = 0; i < ROMN; i++) rom[i] = enc(0, 0);
        rom[0] = enc(13, 5'b10100); rom[1] = enc(4, 3); rom[3] = enc(4, 3);
        run(10, hc);
        chk(pc_o[12:10] == 3'b101, "R9", "latched upper pc", pc_o[12:10], 5);

        // random programs
        for (int p = 0; p < 12; p++) begin
            for (int i = 0; i < ROMN; i++) rom[i] = rand_ins();
            run(250, hc);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule